// File: doc/BRIEF.md
# OTG Controller Register Bridge

This block is the 32-bit register slave that sits in front of an embedded USB on-the-go controller core. It looks at the low 12 bits of each bus address and sends the access to one of three places. A 512-byte window goes straight through to the core's own registers. A second 512-byte window collapses onto the core's per-endpoint FIFO data registers. The upper half of the space is a small local register file that is held in this block.

The local file holds:
- a device configuration word, whose host-mode bit is brought out as a pin;
- a configuration register for the control endpoint;
- one transfer-size register for each IN endpoint and one for each OUT endpoint;
- a scratch word;
- a production-test reset word;
- fixed revision words.

Each write to an endpoint size register also sends a one-cycle size command to the core. The command carries the endpoint number, the transfer length and the direction. Core accesses use a single-outstanding valid/ready request port, and the bus access is held until the core answers it.

The bus protocol works as follows. The master raises `bus_req` with its command fields and holds them until `bus_ack` pulses for one cycle. It then drops `bus_req`.

Top module: `otg_reg_bridge`

## Requirements
- R1: After reset `bus_ack`, `core_req_valid`, `size_cmd_valid`, `host_mode` and `cfg_error` are low. The device configuration word (offset 0x800) and the scratch word (0x9C4) read 0, and the test-reset word (0x9D8) reads 0xA596.
- R2: An access at offsets 0x400–0x5FF becomes one core request. The request carries the address bits 8:0, the same write flag, the same size code and the same write data. On a read, the core's response data is returned on `bus_rdata`.
- R3: An access at offsets 0x600–0x7FF becomes a core request at address 0x20 + 4·addr[8:5]. Every 32-byte slice of the window therefore maps to one endpoint FIFO register in the range 0x20–0x5C.
- R4: A core request stays valid, with stable address and data, until `core_req_ready` is seen. Only one request is outstanding at a time. `bus_ack` is raised only after `core_rsp_valid` returns.
- R5: The size codes are 0 = byte, 1 = halfword and 2 = word. Byte and halfword accesses are forwarded in both core windows. In the local region, any access that is not a word access reads 0, changes no register and sends no size command.
- R6: Offsets 0x000–0x3FF, and local offsets that no register occupies, read 0. Writes to them have no effect.
- R7: The IN size register i (i = 0..14) is at 0x90C + 4i. It stores all 32 bits: bit 31 is an enable flag and bits 30:0 are the length. A write sends a command with endpoint i+1, length = bits 30:0 and tx = 1.
- R8: The OUT size register i is at 0x94C + 4i. It is stored like an IN register, and a write sends a command with endpoint i+1 and tx = 0.
- R9: The control-endpoint register at 0x908 keeps only bits 8:0. A write sends a command with endpoint 0, length = bits 6:0 and tx = bit 7.
- R10: The words at 0x814 and 0x838 read the constant 0x20. The words at 0x880 and 0x900 read the constant 0x30.
- R11: The scratch word is a full 32-bit read/write register. The test-reset word stores bits 15:0 of a write and reads back zero-extended.
- R12: `host_mode` follows bit 16 of the last value written to the device configuration word. Writing that word with bit 15 set raises `cfg_error`, which stays high until reset.
- R13: The maximum-packet range 0x988–0x9C3 and the wait-count word 0x9C8 read 0. Writes to them are discarded and send no size command.
- R14: A local access is acknowledged on the cycle after the bus request is sampled. A size command pulses in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | 12 | Byte offset inside the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | One-cycle completion pulse |
| core_req_valid | output | 1 | Core request valid |
| core_req_ready | input | 1 | Core accepts the request |
| core_req_we | output | 1 | Core request write flag |
| core_req_size | output | 2 | Core request size code |
| core_req_addr | output | 9 | Core register address |
| core_req_wdata | output | 32 | Core write data |
| core_rsp_valid | input | 1 | Core response valid |
| core_rsp_rdata | input | 32 | Core response data |
| size_cmd_valid | output | 1 | Size command pulse |
| size_cmd_ep | output | 4 | Endpoint number of the command |
| size_cmd_len | output | 31 | Transfer length |
| size_cmd_tx | output | 1 | 1 = transmit direction |
| host_mode | output | 1 | Host-mode flag from the device configuration |
| cfg_error | output | 1 | Sticky illegal-configuration flag |

## Verification
The FIFO window is tried at the first and last byte of one slice, at the neighbouring slice, at the top slice, and with a halfword at an unaligned offset. Together these show whether the remap uses the right address bits, and separate it from a plain pass-through. Pass-through accesses use all three sizes at both ends of their window, and the core model answers after 0, 1 and 4 cycles of stall. This shows whether the request is held and whether the acknowledge waits for the response.

Size registers are written at the first and last endpoint of each bank, with patterns that have the enable bit set or clear. The control register is written with high bits that must be dropped. These cases separate the endpoint numbering, the direction and the masking. Reserved, unknown and narrow local accesses are each followed by reads and by watching the command port. This shows that they change nothing.

// File: rtl/otg_bridge_pkg.sv
package otg_bridge_pkg;

   typedef enum logic [1:0] {
      REG_NONE,
      REG_CORE,
      REG_FIFO,
      REG_LOCAL
   } region_e;

   typedef enum logic [1:0] {
      BUS_IDLE,
      BUS_CORE,
      BUS_ACK
   } bus_st_e;

   typedef enum logic [1:0] {
      CP_IDLE,
      CP_REQ,
      CP_WAIT
   } core_st_e;

   localparam logic [1:0] XFER_BYTE = 2'd0;
   localparam logic [1:0] XFER_HALF = 2'd1;
   localparam logic [1:0] XFER_WORD = 2'd2;

   localparam logic [31:0] REV_PWR  = 32'h20;
   localparam logic [31:0] REV_IRQ  = 32'h20;
   localparam logic [31:0] REV_GPIO = 32'h30;
   localparam logic [31:0] REV_DMA  = 32'h30;

   localparam logic [15:0] TEST_RST_INIT = 16'hA596;

   typedef struct packed {
      logic [3:0]  ep;
      logic [30:0] len;
      logic        tx;
   } size_cmd_t;

endpackage

// File: rtl/otg_addr_decode.sv
module otg_addr_decode
   import otg_bridge_pkg::*;
#(
   parameter int CORE_AW   = 9,
   parameter int FIFO_BASE = 32'h20
) (
   input  logic [11:0]        off,
   output region_e            region,
   output logic [CORE_AW-1:0] core_addr
);

   localparam int FIFO_MASK = 32'h3C;

   logic [31:0] fifo_addr;

   // One 32-byte slice of the FIFO window selects one endpoint FIFO register.
   assign fifo_addr = FIFO_BASE + ((32'(off) >> 3) & FIFO_MASK);

   always_comb begin
      region    = REG_NONE;
      core_addr = '0;
      unique casez (off[11:9])
         3'b010: begin
            region    = REG_CORE;
            core_addr = off[CORE_AW-1:0];
         end
         3'b011: begin
            region    = REG_FIFO;
            core_addr = fifo_addr[CORE_AW-1:0];
         end
         3'b1??: region = REG_LOCAL;
         default: region = REG_NONE;
      endcase
   end

endmodule

// File: rtl/otg_core_port.sv
module otg_core_port
   import otg_bridge_pkg::*;
#(
   parameter int CORE_AW = 9,
   parameter int DW      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               we,
   input  logic [1:0]         size,
   input  logic [CORE_AW-1:0] addr,
   input  logic [DW-1:0]      wdata,
   output logic               core_req_valid,
   input  logic               core_req_ready,
   output logic               core_req_we,
   output logic [1:0]         core_req_size,
   output logic [CORE_AW-1:0] core_req_addr,
   output logic [DW-1:0]      core_req_wdata,
   input  logic               core_rsp_valid,
   input  logic [DW-1:0]      core_rsp_rdata,
   output logic               done,
   output logic [DW-1:0]      rdata
);

   core_st_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st             <= CP_IDLE;
         core_req_we    <= 1'b0;
         core_req_size  <= XFER_WORD;
         core_req_addr  <= '0;
         core_req_wdata <= '0;
      end else begin
         unique case (st)
            CP_IDLE: if (start) begin
               st             <= CP_REQ;
               core_req_we    <= we;
               core_req_size  <= size;
               core_req_addr  <= addr;
               core_req_wdata <= wdata;
            end
            CP_REQ:  if (core_req_ready) st <= CP_WAIT;
            CP_WAIT: if (core_rsp_valid) st <= CP_IDLE;
            default: st <= CP_IDLE;
         endcase
      end
   end

   assign core_req_valid = (st == CP_REQ);
   assign done           = (st == CP_WAIT) && core_rsp_valid;
   assign rdata          = core_rsp_rdata;

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (core_req_valid && !core_req_ready) |=>
         (core_req_valid && $stable(core_req_addr) && $stable(core_req_wdata)));

endmodule

// File: rtl/otg_local_regs.sv
module otg_local_regs
   import otg_bridge_pkg::*;
#(
   parameter int NUM_EP = 15,
   parameter int DW     = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          acc_en,
   input  logic          acc_we,
   input  logic [8:0]    widx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          host_mode,
   output logic          cfg_error,
   output logic          cmd_vld,
   output size_cmd_t     cmd_q
);

   // word indices inside the local block
   localparam logic [8:0] W_DEVCFG  = 9'h000;
   localparam logic [8:0] W_REV_PWR = 9'h005;
   localparam logic [8:0] W_REV_IRQ = 9'h00E;
   localparam logic [8:0] W_REV_GPIO= 9'h020;
   localparam logic [8:0] W_REV_DMA = 9'h040;
   localparam logic [8:0] W_EP0     = 9'h042;
   localparam logic [8:0] W_IN      = 9'h043;
   localparam logic [8:0] W_OUT     = 9'h053;
   localparam logic [8:0] W_MPS     = 9'h062;
   localparam logic [8:0] W_SCRATCH = 9'h071;
   localparam logic [8:0] W_WAIT    = 9'h072;
   localparam logic [8:0] W_TSTRST  = 9'h076;
   localparam logic [8:0] EP_SPAN   = 9'(NUM_EP);
   localparam logic [8:0] MPS_SPAN  = 9'd15;
   localparam int         HOST_BIT  = 16;
   localparam int         PTEST_BIT = 15;
   localparam int         EP0_W     = 9;

   logic [DW-1:0]    dev_cfg, scratch;
   logic [EP0_W-1:0] ep0_cfg;
   logic [15:0]      test_rst;
   logic [DW-1:0]    in_sz  [NUM_EP];
   logic [DW-1:0]    out_sz [NUM_EP];
   logic [8:0]       in_rel, out_rel;
   logic             in_hit, out_hit, wr;

   assign wr      = acc_en && acc_we;
   assign in_rel  = widx - W_IN;
   assign out_rel = widx - W_OUT;
   assign in_hit  = (widx >= W_IN)  && (in_rel  < EP_SPAN);
   assign out_hit = (widx >= W_OUT) && (out_rel < EP_SPAN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_cfg   <= '0;
         scratch   <= '0;
         ep0_cfg   <= '0;
         test_rst  <= TEST_RST_INIT;
         cfg_error <= 1'b0;
      end else if (wr) begin
         unique case (widx)
            W_DEVCFG: begin
               dev_cfg <= wdata;
               if (wdata[PTEST_BIT]) cfg_error <= 1'b1;
            end
            W_EP0:     ep0_cfg  <= wdata[EP0_W-1:0];
            W_SCRATCH: scratch  <= wdata;
            W_TSTRST:  test_rst <= wdata[15:0];
            default: ;
         endcase
      end
   end

   assign host_mode = dev_cfg[HOST_BIT];

   for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            in_sz[i]  <= '0;
            out_sz[i] <= '0;
         end else begin
            if (wr && in_hit  && (in_rel  == 9'(i))) in_sz[i]  <= wdata;
            if (wr && out_hit && (out_rel == 9'(i))) out_sz[i] <= wdata;
         end
      end
   end

   // size command toward the core, one pulse per size-register write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_vld <= 1'b0;
         cmd_q   <= '0;
      end else begin
         cmd_vld <= 1'b0;
         if (wr && widx == W_EP0) begin
            cmd_vld   <= 1'b1;
            cmd_q.ep  <= 4'd0;
            cmd_q.len <= {24'd0, wdata[6:0]};
            cmd_q.tx  <= wdata[7];
         end else if (wr && in_hit) begin
            cmd_vld   <= 1'b1;
            cmd_q.ep  <= 4'(in_rel) + 4'd1;
            cmd_q.len <= wdata[30:0];
            cmd_q.tx  <= 1'b1;
         end else if (wr && out_hit) begin
            cmd_vld   <= 1'b1;
            cmd_q.ep  <= 4'(out_rel) + 4'd1;
            cmd_q.len <= wdata[30:0];
            cmd_q.tx  <= 1'b0;
         end
      end
   end

   always_comb begin
      rdata = '0;
      unique case (widx)
         W_DEVCFG:   rdata = dev_cfg;
         W_REV_PWR:  rdata = REV_PWR;
         W_REV_IRQ:  rdata = REV_IRQ;
         W_REV_GPIO: rdata = REV_GPIO;
         W_REV_DMA:  rdata = REV_DMA;
         W_EP0:      rdata = DW'(ep0_cfg);
         W_SCRATCH:  rdata = scratch;
         W_WAIT:     rdata = '0;
         W_TSTRST:   rdata = DW'(test_rst);
         default:    rdata = '0;
      endcase
      if ((widx >= W_MPS) && (widx - W_MPS < MPS_SPAN)) rdata = '0;
      for (int i = 0; i < NUM_EP; i++) begin
         if (in_hit  && in_rel  == 9'(i)) rdata = in_sz[i];
         if (out_hit && out_rel == 9'(i)) rdata = out_sz[i];
      end
   end

   // R12
   cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_error |=> cfg_error);

   // R9
   ep0_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_q.ep == 4'd0) |-> (cmd_q.len[30:7] == 24'd0));

   // R7
   ep_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_vld |-> (32'(cmd_q.ep) <= NUM_EP));

endmodule

// File: rtl/otg_reg_bridge.sv
module otg_reg_bridge
   import otg_bridge_pkg::*;
#(
   parameter int NUM_EP  = 15,
   parameter int DATA_W  = 32,
   parameter int CORE_AW = 9
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_req,
   input  logic                bus_we,
   input  logic [1:0]          bus_size,
   input  logic [11:0]         bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   output logic                bus_ack,
   output logic                core_req_valid,
   input  logic                core_req_ready,
   output logic                core_req_we,
   output logic [1:0]          core_req_size,
   output logic [CORE_AW-1:0]  core_req_addr,
   output logic [DATA_W-1:0]   core_req_wdata,
   input  logic                core_rsp_valid,
   input  logic [DATA_W-1:0]   core_rsp_rdata,
   output logic                size_cmd_valid,
   output logic [3:0]          size_cmd_ep,
   output logic [30:0]         size_cmd_len,
   output logic                size_cmd_tx,
   output logic                host_mode,
   output logic                cfg_error
);

   if (NUM_EP < 1 || NUM_EP > 15) begin : g_bad_ep
      $error("NUM_EP must lie in 1..15");
   end
   if (DATA_W != 32) begin : g_bad_dw
      $error("DATA_W must be 32");
   end
   if (CORE_AW != 9) begin : g_bad_aw
      $error("CORE_AW must be 9");
   end

   region_e             region;
   logic [CORE_AW-1:0]  dec_addr;
   logic [DATA_W-1:0]   loc_rdata, core_rdata, rdata_q;
   logic                take, is_core, loc_acc, core_done;
   bus_st_e             st;
   size_cmd_t           cmd;

   otg_addr_decode #(.CORE_AW(CORE_AW)) u_dec (
      .off       (bus_addr),
      .region    (region),
      .core_addr (dec_addr)
   );

   assign take    = (st == BUS_IDLE) && bus_req;
   assign is_core = (region == REG_CORE) || (region == REG_FIFO);
   assign loc_acc = take && (region == REG_LOCAL) && (bus_size == XFER_WORD);

   otg_core_port #(.CORE_AW(CORE_AW), .DW(DATA_W)) u_port (
      .clk            (clk),
      .rst_n          (rst_n),
      .start          (take && is_core),
      .we             (bus_we),
      .size           (bus_size),
      .addr           (dec_addr),
      .wdata          (bus_wdata),
      .core_req_valid (core_req_valid),
      .core_req_ready (core_req_ready),
      .core_req_we    (core_req_we),
      .core_req_size  (core_req_size),
      .core_req_addr  (core_req_addr),
      .core_req_wdata (core_req_wdata),
      .core_rsp_valid (core_rsp_valid),
      .core_rsp_rdata (core_rsp_rdata),
      .done           (core_done),
      .rdata          (core_rdata)
   );

   otg_local_regs #(.NUM_EP(NUM_EP), .DW(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_en    (loc_acc),
      .acc_we    (bus_we),
      .widx      (bus_addr[10:2]),
      .wdata     (bus_wdata),
      .rdata     (loc_rdata),
      .host_mode (host_mode),
      .cfg_error (cfg_error),
      .cmd_vld   (size_cmd_valid),
      .cmd_q     (cmd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= BUS_IDLE;
         rdata_q <= '0;
      end else begin
         unique case (st)
            BUS_IDLE: if (take) begin
               if (is_core) begin
                  st <= BUS_CORE;
               end else begin
                  st      <= BUS_ACK;
                  rdata_q <= (loc_acc && !bus_we) ? loc_rdata : '0;
               end
            end
            BUS_CORE: if (core_done) begin
               st      <= BUS_ACK;
               rdata_q <= core_rdata;
            end
            BUS_ACK:  st <= BUS_IDLE;
            default:  st <= BUS_IDLE;
         endcase
      end
   end

   assign bus_ack      = (st == BUS_ACK);
   assign bus_rdata    = rdata_q;
   assign size_cmd_ep  = cmd.ep;
   assign size_cmd_len = cmd.len;
   assign size_cmd_tx  = cmd.tx;

   // R14
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ack |=> !bus_ack);

   // R14
   cmd_with_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      size_cmd_valid |-> bus_ack);

   // R4
   no_ack_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_req_valid |-> !bus_ack);

endmodule

// File: tb/otg_reg_bridge_tb_top.sv
module otg_reg_bridge_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0, bus_we = 1'b0;
   logic [1:0]  bus_size = 2'd2;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_ack;
   logic        core_req_valid, core_req_we;
   logic        core_req_ready = 1'b0;
   logic [1:0]  core_req_size;
   logic [8:0]  core_req_addr;
   logic [31:0] core_req_wdata;
   logic        core_rsp_valid = 1'b0;
   logic [31:0] core_rsp_rdata = '0;
   logic        size_cmd_valid, size_cmd_tx, host_mode, cfg_error;
   logic [3:0]  size_cmd_ep;
   logic [30:0] size_cmd_len;

   int checks = 0;
   int errors = 0;
   int stall_target = 0;

   logic [31:0] exp_rd_q[$];
   bit          exp_chk_q[$];
   string       exp_tag_q[$];
   logic [43:0] exp_core_q[$];
   string       core_tag_q[$];
   logic [35:0] exp_cmd_q[$];
   string       cmd_tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   otg_reg_bridge dut_i (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
      .core_req_valid(core_req_valid), .core_req_ready(core_req_ready),
      .core_req_we(core_req_we), .core_req_size(core_req_size),
      .core_req_addr(core_req_addr), .core_req_wdata(core_req_wdata),
      .core_rsp_valid(core_rsp_valid), .core_rsp_rdata(core_rsp_rdata),
      .size_cmd_valid(size_cmd_valid), .size_cmd_ep(size_cmd_ep),
      .size_cmd_len(size_cmd_len), .size_cmd_tx(size_cmd_tx),
      .host_mode(host_mode), .cfg_error(cfg_error)
   );

   task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- bus monitor: pops expected read data on each acknowledge
   always @(negedge clk) begin
      if (rst_n && bus_ack) begin
         if (exp_rd_q.size() == 0) begin
            check(1'b0, "R14 unexpected acknowledge", 64'd1, 64'd0);
         end else begin
            logic [31:0] e;
            bit c;
            string t;
            e = exp_rd_q.pop_front();
            c = exp_chk_q.pop_front();
            t = exp_tag_q.pop_front();
            if (c) check(bus_rdata == e, t, 64'(bus_rdata), 64'(e));
         end
      end
   end

   // ---------------- size-command monitor
   always @(negedge clk) begin
      if (rst_n && size_cmd_valid) begin
         if (exp_cmd_q.size() == 0) begin
            check(1'b0, "R5/R13 unexpected size command", 64'({size_cmd_ep, size_cmd_len, size_cmd_tx}), 64'd0);
         end else begin
            logic [35:0] e;
            string t;
            e = exp_cmd_q.pop_front();
            t = cmd_tag_q.pop_front();
            check({size_cmd_ep, size_cmd_len, size_cmd_tx} == e, t,
                  64'({size_cmd_ep, size_cmd_len, size_cmd_tx}), 64'(e));
         end
      end
   end

   // ---------------- core model: stalls ready, answers two cycles after accept
   int  stall_cnt = 0;
   int  rsp_cnt = 0;
   bit  pending = 0;
   bit  prev_wait = 0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_wait && !core_req_valid)
            check(1'b0, "R4 request dropped before ready", 64'd0, 64'd1);
         if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
               core_rsp_valid = 1'b1;
               core_rsp_rdata = 32'h5A00_0000 | 32'(core_req_addr);
            end
         end else if (core_rsp_valid) begin
            core_rsp_valid = 1'b0;
            pending = 0;
         end
         if (core_req_ready) begin
            core_req_ready = 1'b0;
         end else if (core_req_valid && !pending) begin
            if (stall_cnt >= stall_target) begin
               core_req_ready = 1'b1;
               stall_cnt = 0;
               pending = 1;
               rsp_cnt = 2;
               if (exp_core_q.size() == 0) begin
                  check(1'b0, "R2 unexpected core request", 64'(core_req_addr), 64'd0);
               end else begin
                  logic [43:0] e;
                  string t;
                  e = exp_core_q.pop_front();
                  t = core_tag_q.pop_front();
                  check({core_req_we, core_req_size, core_req_addr, core_req_wdata} == e, t,
                        64'({core_req_we, core_req_size, core_req_addr, core_req_wdata}), 64'(e));
               end
            end else begin
               stall_cnt++;
            end
         end
         if (pending && bus_ack)
            check(1'b0, "R4 acknowledge before core response", 64'd1, 64'd0);
         prev_wait = core_req_valid && !core_req_ready;
      end
   end

   // ---------------- driver
   task automatic bus_op(input logic we, input logic [1:0] sz, input logic [11:0] a,
                         input logic [31:0] wd, input logic [31:0] exp, input bit chk,
                         input string tag, input bit chk_lat);
      int lat;
      exp_rd_q.push_back(exp);
      exp_chk_q.push_back(chk);
      exp_tag_q.push_back(tag);
      @(negedge clk);
      bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
      lat = 0;
      do begin
         @(negedge clk);
         lat++;
      end while (!bus_ack);
      bus_req = 1'b0;
      if (chk_lat) check(lat == 1, "R14 local acknowledge latency", 64'(lat), 64'd1);
   endtask

   task automatic loc_wr(input logic [11:0] a, input logic [31:0] wd, input string tag);
      bus_op(1'b1, 2'd2, a, wd, 32'd0, 1'b0, tag, 1'b1);
   endtask

   task automatic loc_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
      bus_op(1'b0, 2'd2, a, 32'd0, exp, 1'b1, tag, 1'b1);
   endtask

   task automatic core_op(input logic we, input logic [1:0] sz, input logic [11:0] a,
                          input logic [31:0] wd, input logic [8:0] exp_addr, input string tag);
      exp_core_q.push_back({we, sz, exp_addr, wd});
      core_tag_q.push_back(tag);
      bus_op(we, sz, a, wd, 32'h5A00_0000 | 32'(exp_addr), !we, tag, 1'b0);
   endtask

   task automatic exp_cmd(input logic [3:0] ep, input logic [30:0] len, input logic tx, input string tag);
      exp_cmd_q.push_back({ep, len, tx});
      cmd_tag_q.push_back(tag);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R4 watchdog expired", 64'd0, 64'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!bus_ack && !core_req_valid && !size_cmd_valid, "R1 idle outputs after reset",
            64'({bus_ack, core_req_valid, size_cmd_valid}), 64'd0);
      check(!host_mode && !cfg_error, "R1 flags after reset", 64'({host_mode, cfg_error}), 64'd0);
      loc_rd(12'h9D8, 32'h0000_A596, "R1 test-reset initial value");
      loc_rd(12'h800, 32'h0, "R1 device config initial value");
      loc_rd(12'h9C4, 32'h0, "R1 scratch initial value");

      // R2 pass-through, R5 sizes, R4 stalls
      stall_target = 0;
      core_op(1'b1, 2'd2, 12'h404, 32'h1122_3344, 9'h004, "R2 word write pass-through");
      stall_target = 1;
      core_op(1'b0, 2'd0, 12'h5FF, 32'h0, 9'h1FF, "R5 byte read pass-through");
      stall_target = 4;
      core_op(1'b0, 2'd1, 12'h47E, 32'h0, 9'h07E, "R4 halfword read with long stall");
      core_op(1'b0, 2'd2, 12'h400, 32'h0, 9'h000, "R2 word read at window start");

      // R3 FIFO remap
      stall_target = 0;
      core_op(1'b0, 2'd2, 12'h600, 32'h0, 9'h020, "R3 fifo slice 0 first byte");
      core_op(1'b0, 2'd0, 12'h61F, 32'h0, 9'h020, "R3 fifo slice 0 last byte");
      stall_target = 2;
      core_op(1'b0, 2'd2, 12'h620, 32'h0, 9'h024, "R3 fifo slice 1");
      core_op(1'b0, 2'd2, 12'h7E4, 32'h0, 9'h05C, "R3 fifo top slice");
      core_op(1'b1, 2'd1, 12'h6A2, 32'h0000_BEEF, 9'h034, "R3 fifo halfword write");
      stall_target = 0;

      // R7 IN sizes
      exp_cmd(4'd1, 31'h40, 1'b1, "R7 IN endpoint 1 command");
      loc_wr(12'h90C, 32'h8000_0040, "R7 IN write ep1");
      loc_rd(12'h90C, 32'h8000_0040, "R7 IN readback ep1");
      exp_cmd(4'd15, 31'h7FFF_FFFF, 1'b1, "R7 IN endpoint 15 command");
      loc_wr(12'h944, 32'h7FFF_FFFF, "R7 IN write ep15");
      loc_rd(12'h944, 32'h7FFF_FFFF, "R7 IN readback ep15");

      // R8 OUT sizes
      exp_cmd(4'd1, 31'h200, 1'b0, "R8 OUT endpoint 1 command");
      loc_wr(12'h94C, 32'h0000_0200, "R8 OUT write ep1");
      exp_cmd(4'd15, 31'h7FFF_FFFF, 1'b0, "R8 OUT endpoint 15 command");
      loc_wr(12'h984, 32'hFFFF_FFFF, "R8 OUT write ep15");
      loc_rd(12'h984, 32'hFFFF_FFFF, "R8 OUT readback ep15");
      loc_rd(12'h94C, 32'h0000_0200, "R8 OUT readback ep1");

      // R9 control endpoint
      exp_cmd(4'd0, 31'h45, 1'b1, "R9 ep0 command tx");
      loc_wr(12'h908, 32'hFFFF_FEC5, "R9 ep0 write");
      loc_rd(12'h908, 32'h0000_00C5, "R9 ep0 masked readback");
      exp_cmd(4'd0, 31'h03, 1'b0, "R9 ep0 command rx");
      loc_wr(12'h908, 32'h0000_0103, "R9 ep0 write rx");
      loc_rd(12'h908, 32'h0000_0103, "R9 ep0 readback rx");

      // R10 revision constants
      loc_rd(12'h814, 32'h20, "R10 power revision");
      loc_rd(12'h838, 32'h20, "R10 interrupt revision");
      loc_rd(12'h880, 32'h30, "R10 gpio revision");
      loc_rd(12'h900, 32'h30, "R10 dma revision");

      // R11 scratch and test reset
      loc_wr(12'h9C4, 32'hDEAD_BEEF, "R11 scratch write");
      loc_rd(12'h9C4, 32'hDEAD_BEEF, "R11 scratch readback");
      loc_wr(12'h9D8, 32'h1234_5678, "R11 test-reset write");
      loc_rd(12'h9D8, 32'h0000_5678, "R11 test-reset readback");

      // R12 device configuration
      loc_wr(12'h800, 32'h0001_0000, "R12 host mode write");
      check(host_mode && !cfg_error, "R12 host mode set", 64'({host_mode, cfg_error}), 64'd2);
      loc_rd(12'h800, 32'h0001_0000, "R12 device config readback");
      loc_wr(12'h800, 32'h0000_8000, "R12 product test write");
      check(!host_mode && cfg_error, "R12 error raised", 64'({host_mode, cfg_error}), 64'd1);
      loc_wr(12'h800, 32'h0000_0000, "R12 clear write");
      check(cfg_error, "R12 error sticky", 64'(cfg_error), 64'd1);

      // R13 reserved ranges
      loc_wr(12'h988, 32'hFFFF_FFFF, "R13 max packet write");
      loc_rd(12'h988, 32'h0, "R13 max packet first reads zero");
      loc_wr(12'h9C0, 32'hFFFF_FFFF, "R13 max packet last write");
      loc_rd(12'h9C0, 32'h0, "R13 max packet last reads zero");
      loc_wr(12'h9C8, 32'h0000_FFFF, "R13 wait count write");
      loc_rd(12'h9C8, 32'h0, "R13 wait count reads zero");

      // R6 unknown offsets
      loc_wr(12'h004, 32'hFFFF_FFFF, "R6 low region write");
      loc_rd(12'h004, 32'h0, "R6 low region reads zero");
      loc_rd(12'h3FC, 32'h0, "R6 low region top reads zero");
      loc_wr(12'hA00, 32'hFFFF_FFFF, "R6 upper unused write");
      loc_rd(12'hA00, 32'h0, "R6 upper unused reads zero");
      loc_rd(12'h9CC, 32'h0, "R6 hole reads zero");

      // R5 narrow local accesses are ignored
      bus_op(1'b1, 2'd0, 12'h9C4, 32'h0000_0011, 32'h0, 1'b0, "R5 byte write scratch", 1'b1);
      loc_rd(12'h9C4, 32'hDEAD_BEEF, "R5 scratch unchanged after byte write");
      bus_op(1'b0, 2'd1, 12'h9C4, 32'h0, 32'h0, 1'b1, "R5 halfword local read is zero", 1'b1);
      bus_op(1'b1, 2'd0, 12'h90C, 32'h0000_0001, 32'h0, 1'b0, "R5 byte write IN size", 1'b1);
      loc_rd(12'h90C, 32'h8000_0040, "R5 IN size unchanged after byte write");

      repeat (5) @(negedge clk);
      check(exp_rd_q.size() == 0 && exp_core_q.size() == 0 && exp_cmd_q.size() == 0,
            "R4 outstanding expectations at end",
            64'(exp_rd_q.size() + exp_core_q.size() + exp_cmd_q.size()), 64'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule